// File: doc/BRIEF.md
# CRC-Gated Packet Release Buffer

This block sits between a packet assembler and a serial consumer such as a pulse-position modulator. The assembler may present a fresh 112-bit candidate packet on every received bit, so candidates can overlap and most of them are noise. The block takes one candidate at a time and feeds its bits, most significant first, into a bit-serial 24-bit parity divider. In the same cycle it copies each bit into a separate output buffer. Only a candidate whose full 112-bit word divides evenly by the generator is handed downstream.

An accepted candidate needs 112 shift cycles and one evaluation cycle. After that the block either waits for the consumer to be ready and emits a one-cycle release strobe, or clears the buffer and returns to idle. Candidates that arrive while the block is busy are discarded. A saturating counter records each one that is discarded.

Top module: `pkt_crc_gate`

## Requirements
- R1: While reset is asserted and after it is released, `relStrobe`, `matchFlag`, `relData` and `dropCount` all read zero until a candidate completes.
- R2: A candidate whose 112-bit word (first bit = bit 111) leaves a zero remainder when divided by the generator x^24 + 0xFFF409 is released: `relData` equals the candidate while `relStrobe` is high, and every release matches one such candidate, in order.
- R3: A candidate with a nonzero remainder produces no release strobe. `matchFlag` reads 0 and `relData` reads all zeros after its evaluation.
- R4: If a candidate is accepted on clock edge k, `matchFlag` takes its result on edge k+113 and holds its previous value before that edge.
- R5: A `candValid` pulse that is sampled while a check, an evaluation or a pending release is in progress is ignored. It increments `dropCount` by one.
- R6: A matching packet waits in the buffer with `relData` stable while `downReady` is low. `relStrobe` rises one cycle after the edge that samples `downReady` high, and stays high for exactly one cycle.
- R7: `dropCount` saturates at its all-ones value (15 when DROP_W = 4) and never wraps.
- R8: A candidate presented in the same cycle as a release strobe is accepted and checked normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| candValid | input | 1 | One-cycle pulse qualifying candData |
| candData | input | PKT_W (112) | Candidate packet, bit 111 sent first |
| downReady | input | 1 | Consumer can take a released packet |
| relStrobe | output | 1 | One-cycle strobe, relData is valid |
| relData | output | PKT_W (112) | Output buffer contents |
| matchFlag | output | 1 | Result of the most recent parity evaluation |
| dropCount | output | DROP_W | Saturating count of ignored candidates |

## Verification
The assertions assume that `downReady` and `candValid` are ordinary synchronous inputs that settle well before each rising edge. They also assume that reset is held for at least one edge, so the history they compare starts from the reset values. The stimulus changes every input one time unit after a falling edge and samples outputs two units after it. Candidates are built by long division of 88 random-looking data bits, with a single flipped bit to make mismatches. Drops are provoked on purpose in the shifting, evaluation and waiting phases, and with a long held valid that drives the counter into saturation.

// File: rtl/pkt_crc_gate_pkg.sv
package pkt_crc_gate_pkg;

  // Strobes from the control FSM into the datapath
  typedef struct packed {
    logic load;   // capture a new candidate, clear buffer and remainder
    logic shift;  // move one bit into the divider and the output buffer
    logic eval;   // latch the match result, clear the buffer on mismatch
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_EVAL  = 2'd2,
    ST_HOLD  = 2'd3
  } gateState_t;

endpackage

// File: rtl/pkt_crc_gate_dp.sv
module pkt_crc_gate_dp
  import pkt_crc_gate_pkg::*;
#(
  parameter int              PKT_W = 112,
  parameter int              CRC_W = 24,
  parameter logic [CRC_W-1:0] POLY = 24'hFFF409
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [PKT_W-1:0] candData,
  output logic             crcZero,
  output logic [PKT_W-1:0] relData,
  output logic             matchFlag
);

  logic [PKT_W-1:0] inReg;
  logic [PKT_W-1:0] outBuf;
  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] crcNext;
  logic             headBit;
  logic             feedBack;

  assign headBit  = inReg[PKT_W-1];
  assign feedBack = crcReg[CRC_W-1] ^ headBit;

  // One step of bit-serial polynomial division, first bit = MSB
  always_comb begin
    crcNext = {crcReg[CRC_W-2:0], 1'b0};
    if (feedBack) crcNext = crcNext ^ POLY;
  end

  assign crcZero = (crcReg == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inReg     <= '0;
      outBuf    <= '0;
      crcReg    <= '0;
      matchFlag <= 1'b0;
    end else if (strobe.load) begin
      inReg  <= candData;
      outBuf <= '0;
      crcReg <= '0;
    end else if (strobe.shift) begin
      inReg  <= {inReg[PKT_W-2:0], 1'b0};
      outBuf <= {outBuf[PKT_W-2:0], headBit};
      crcReg <= crcNext;
    end else if (strobe.eval) begin
      matchFlag <= crcZero;
      if (!crcZero) outBuf <= '0;
    end
  end

  assign relData = outBuf;

endmodule

// File: rtl/pkt_crc_gate_ctrl.sv
module pkt_crc_gate_ctrl
  import pkt_crc_gate_pkg::*;
#(
  parameter int PKT_W  = 112,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              candValid,
  input  logic              downReady,
  input  logic              crcZero,
  output dpStrobe_t         strobe,
  output logic              relStrobe,
  output logic [DROP_W-1:0] dropCount
);

  localparam int              CNT_W    = $clog2(PKT_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(PKT_W - 1);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  gateState_t       state;
  logic [CNT_W-1:0] bitCnt;
  logic             busy;

  assign busy = (state != ST_IDLE);

  always_comb begin
    strobe       = '0;
    strobe.load  = (state == ST_IDLE) && candValid;
    strobe.shift = (state == ST_SHIFT);
    strobe.eval  = (state == ST_EVAL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      relStrobe <= 1'b0;
    end else begin
      relStrobe <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (candValid) begin
            state  <= ST_SHIFT;
            bitCnt <= '0;
          end
        end
        ST_SHIFT: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == LAST_BIT) state <= ST_EVAL;
        end
        ST_EVAL: begin
          state <= crcZero ? ST_HOLD : ST_IDLE;
        end
        ST_HOLD: begin
          if (downReady) begin
            relStrobe <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Saturating count of candidates that arrive while busy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dropCount <= '0;
    end else if (candValid && busy && (dropCount != DROP_MAX)) begin
      dropCount <= dropCount + 1'b1;
    end
  end

endmodule

// File: rtl/pkt_crc_gate.sv
module pkt_crc_gate
  import pkt_crc_gate_pkg::*;
#(
  parameter int              PKT_W  = 112,
  parameter int              CRC_W  = 24,
  parameter logic [CRC_W-1:0] POLY  = 24'hFFF409,
  parameter int              DROP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              candValid,
  input  logic [PKT_W-1:0]  candData,
  input  logic              downReady,
  output logic              relStrobe,
  output logic [PKT_W-1:0]  relData,
  output logic              matchFlag,
  output logic [DROP_W-1:0] dropCount
);

  dpStrobe_t strobe;
  logic      crcZero;

  pkt_crc_gate_ctrl #(
    .PKT_W (PKT_W),
    .DROP_W(DROP_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .candValid(candValid),
    .downReady(downReady),
    .crcZero  (crcZero),
    .strobe   (strobe),
    .relStrobe(relStrobe),
    .dropCount(dropCount)
  );

  pkt_crc_gate_dp #(
    .PKT_W(PKT_W),
    .CRC_W(CRC_W),
    .POLY (POLY)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .candData (candData),
    .crcZero  (crcZero),
    .relData  (relData),
    .matchFlag(matchFlag)
  );

endmodule

// File: rtl/pkt_crc_gate_chk.sv
module pkt_crc_gate_chk #(
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              candValid,
  input logic              downReady,
  input logic              relStrobe,
  input logic              matchFlag,
  input logic [DROP_W-1:0] dropCount
);

  // R6: a release strobe lasts one cycle
  a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    relStrobe |=> !relStrobe);

  // R6: a release strobe follows an edge that sampled the consumer ready
  a_r6_strobe_after_ready: assert property (@(posedge clk) disable iff (!rstN)
    relStrobe |-> $past(downReady));

  // R2 / R3: only a matching packet is ever released
  a_r2_release_needs_match: assert property (@(posedge clk) disable iff (!rstN)
    relStrobe |-> matchFlag);

  // R5: the drop counter only moves when a candidate was offered
  a_r5_drop_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    (dropCount != $past(dropCount)) |-> $past(candValid));

  // R7: the drop counter steps by at most one and never wraps
  a_r7_drop_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (dropCount == $past(dropCount)) ||
    ((dropCount == $past(dropCount) + 1'b1) && (dropCount != '0)));

endmodule

bind pkt_crc_gate pkt_crc_gate_chk #(
  .DROP_W(DROP_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .candValid(candValid),
  .downReady(downReady),
  .relStrobe(relStrobe),
  .matchFlag(matchFlag),
  .dropCount(dropCount)
);

// File: tb/pkt_crc_gate_bench.sv
`timescale 1ns/1ps
module pkt_crc_gate_bench;

  localparam int PKT_W  = 112;
  localparam int DROP_W = 4;
  localparam int DROP_MAX = 15;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              candValid = 1'b0;
  logic [PKT_W-1:0]  candData = '0;
  logic              downReady = 1'b1;
  logic              relStrobe;
  logic [PKT_W-1:0]  relData;
  logic              matchFlag;
  logic [DROP_W-1:0] dropCount;

  int total = 0;
  int bad   = 0;
  int expDrop = 0;
  logic [PKT_W-1:0] expQ[$];
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pkt_crc_gate #(
    .DROP_W(DROP_W)
  ) u_pkt_crc_gate (
    .clk      (clk),
    .rstN     (rstN),
    .candValid(candValid),
    .candData (candData),
    .downReady(downReady),
    .relStrobe(relStrobe),
    .relData  (relData),
    .matchFlag(matchFlag),
    .dropCount(dropCount)
  );

  task automatic check(input bit ok, input string req,
                       input logic [PKT_W-1:0] act, input logic [PKT_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Build a valid packet: 88 data bits followed by the division remainder
  function automatic logic [PKT_W-1:0] mkPkt(input logic [87:0] d);
    logic [PKT_W-1:0] r;
    r = {d, 24'h0};
    for (int i = PKT_W - 1; i >= 24; i--)
      if (r[i]) r[i -: 25] = r[i -: 25] ^ 25'h1FFF409;
    return {d, r[23:0]};
  endfunction

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic waitN(input int n);
    repeat (n) tick();
  endtask

  // Present one candidate for one cycle; returns one negedge after the accept edge
  task automatic send(input logic [PKT_W-1:0] p, input bit good);
    if (good) expQ.push_back(p);
    candValid = 1'b1;
    candData  = p;
    tick();
    candValid = 1'b0;
  endtask

  task automatic pulseDrop(input logic [PKT_W-1:0] junk);
    candValid = 1'b1;
    candData  = junk;
    tick();
    candValid = 1'b0;
    expDrop = (expDrop < DROP_MAX) ? expDrop + 1 : DROP_MAX;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Scoreboard monitor: every release is compared with the next expected packet
  always @(negedge clk) begin
    #2;
    if (rstN && relStrobe) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected release", relData, '0);
      end else begin
        logic [PKT_W-1:0] e;
        e = expQ.pop_front();
        check(relData == e, "R2 released data", relData, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    logic [PKT_W-1:0] pA, pB, pC, pD, pE;
    pA = mkPkt(88'h8D_4840D6_202CC371C32CE0);
    pB = mkPkt(88'h5A_A55A_0F0F_F0F0_1234_56);
    pC = mkPkt(88'hFF_0000_FFFF_0000_FFFF_00);
    pD = mkPkt(88'h01_2345_6789_ABCD_EF01_23);
    pE = mkPkt(88'hC3_3C3C_C3C3_3C3C_C3C3_3C) ^ (112'h1 << 7);

    // R1: reset state
    waitN(3);
    check(relStrobe == 1'b0, "R1 relStrobe", PKT_W'(relStrobe), '0);
    check(matchFlag == 1'b0, "R1 matchFlag", PKT_W'(matchFlag), '0);
    check(dropCount == '0,   "R1 dropCount", PKT_W'(dropCount), '0);
    check(relData == '0,     "R1 relData",   relData, '0);
    rstN = 1'b1;
    waitN(2);
    check(relData == '0 && !matchFlag, "R1 after release", relData, '0);

    // R2 / R4: good packet, consumer ready
    send(pA, 1'b1);
    waitN(112);
    check(matchFlag == 1'b0, "R4 flag before edge k+113", PKT_W'(matchFlag), '0);
    tick();
    check(matchFlag == 1'b1, "R4 flag at edge k+113", PKT_W'(matchFlag), 1);
    check(relStrobe == 1'b0, "R6 strobe not yet", PKT_W'(relStrobe), '0);
    tick();
    check(relStrobe == 1'b1, "R2 release strobe", PKT_W'(relStrobe), 1);
    tick();
    check(relStrobe == 1'b0, "R6 strobe one cycle", PKT_W'(relStrobe), '0);

    // R3: single-bit error is rejected
    send(pA ^ (112'h1 << 40), 1'b0);
    waitN(113);
    check(matchFlag == 1'b0, "R3 flag low", PKT_W'(matchFlag), '0);
    check(relData == '0, "R3 buffer cleared", relData, '0);
    tick();
    check(relStrobe == 1'b0, "R3 no strobe", PKT_W'(relStrobe), '0);
    waitN(2);

    // R5: drops during shifting and evaluation
    send(pB, 1'b1);
    waitN(3);
    pulseDrop(~pB);
    waitN(107);
    pulseDrop(pC);           // sampled on the last shift edge
    pulseDrop(pD);           // sampled on the evaluation edge
    check(dropCount == DROP_W'(expDrop), "R5 drop count", PKT_W'(dropCount), PKT_W'(expDrop));
    check(matchFlag == 1'b1, "R5 packet survives drops", PKT_W'(matchFlag), 1);
    tick();
    check(relStrobe == 1'b1, "R5 release after drops", PKT_W'(relStrobe), 1);
    waitN(2);

    // R6: hold while the consumer is not ready
    downReady = 1'b0;
    send(pC, 1'b1);
    waitN(113);
    check(matchFlag == 1'b1, "R6 match while waiting", PKT_W'(matchFlag), 1);
    waitN(5);
    check(relStrobe == 1'b0, "R6 no strobe while not ready", PKT_W'(relStrobe), '0);
    check(relData == pC, "R6 data held", relData, pC);
    pulseDrop(pA);           // candidate during pending release
    check(dropCount == DROP_W'(expDrop), "R5 drop while waiting", PKT_W'(dropCount), PKT_W'(expDrop));
    check(relData == pC, "R5 data untouched by drop", relData, pC);
    downReady = 1'b1;
    tick();
    check(relStrobe == 1'b1, "R6 strobe after ready", PKT_W'(relStrobe), 1);

    // R8: candidate in the strobe cycle is accepted
    send(pD, 1'b1);
    check(dropCount == DROP_W'(expDrop), "R8 not dropped", PKT_W'(dropCount), PKT_W'(expDrop));
    waitN(113);
    check(matchFlag == 1'b1, "R8 checked", PKT_W'(matchFlag), 1);
    tick();
    check(relStrobe == 1'b1, "R8 released", PKT_W'(relStrobe), 1);
    waitN(2);

    // R7: long held valid saturates the counter
    candValid = 1'b1;
    candData  = pE;
    tick();                  // accepted
    for (int i = 0; i < 19; i++) begin
      tick();
      expDrop = (expDrop < DROP_MAX) ? expDrop + 1 : DROP_MAX;
    end
    candValid = 1'b0;
    tick();
    check(dropCount == DROP_W'(DROP_MAX), "R7 saturated", PKT_W'(dropCount), PKT_W'(DROP_MAX));
    pulseDrop(pA);
    tick();
    check(dropCount == DROP_W'(expDrop), "R7 no wrap", PKT_W'(dropCount), PKT_W'(expDrop));
    waitN(100);
    check(matchFlag == 1'b0, "R3 corrupted packet rejected", PKT_W'(matchFlag), '0);

    check(expQ.size() == 0, "R2 all good packets released", PKT_W'(expQ.size()), '0);
    finishRun();
  end

endmodule